// File: doc/BRIEF.md
# SECDED-Protected SRAM Wrapper with Fault Injection

This block puts a synchronous single-port word store behind a single-error-correct, double-error-detect codec. Each 64-bit data word is kept together with 8 check bits, so each stored codeword is 72 bits wide. When every byte enable is set, a write encodes the new word and stores it in one cycle. When only some byte enables are set, the block first reads the old codeword and corrects it. In the next cycle it merges in the enabled bytes and writes the result back. Reads return the corrected data one cycle after the request is accepted, together with flags for a corrected error and for an uncorrectable error.

At power-up the array contents are undefined, so an unwritten word would normally read back as an uncorrectable error. For this reason a sequencer fills every word with an all-zero codeword after reset. The block accepts no requests until that sweep has finished. Software can also arm a one-shot fault: it names a codeword bit, and that bit, or that bit and the next one, is inverted in the next word the block commits. This makes it possible to exercise the corrected-error and uncorrectable-error paths. A word that holds a single-bit fault is repaired by writing back the corrected value that a read returned.

Top module: `ecc_sram_wrap`

## Requirements
- R1: After reset, `ready` and `init_done` are low. The sequencer writes an all-zero codeword to every word, one word per cycle. `init_done` rises after DEPTH cycles and then stays high. After that, every word reads as zero with no error flag.
- R2: A write with `be` = 8'hFF stores the encoded word in the acceptance cycle, and `ready` stays high.
- R3: For a read accepted at a clock edge, `rvalid` and `rdata` are valid in the following cycle. Reads may be accepted on consecutive cycles.
- R4: A stored codeword with exactly one inverted bit, in either a data bit or a check bit, reads back as the original data, with `err_corr` = 1 and `err_uncorr` = 0.
- R5: A stored codeword with two inverted bits reads back with `err_uncorr` = 1 and `err_corr` = 0.
- R6: A write with `be` other than 8'hFF is a read-modify-write. `ready` is low for exactly the one cycle after acceptance. Byte b is `wdata[8b+7:8b]` when `be[b]` = 1 and is the corrected old byte when `be[b]` = 0.
- R7: If the old word of a read-modify-write is uncorrectable, `wr_err` and `err_uncorr` are high during the cycle in which `ready` is low. Nothing is written, and the word keeps its fault.
- R8: If the old word of a read-modify-write holds a single-bit fault, `err_corr` is high during the cycle in which `ready` is low. The merged word is then stored fault-free.
- R9: A pulse on `inj_set` arms an injection at codeword bit `inj_idx`. Bits 0 to 63 are data bits and bits 64 to 71 are check bits. When `inj_double` is set, bit `inj_idx`+1 is also inverted. The armed injection applies to the next committed host write only. It then disarms. A read-modify-write that is aborted does not consume it.
- R10: Writing back the corrected data of a word that holds a single-bit fault makes later reads of that word report no error.
- R11: Outside a read response cycle or a read-modify-write cycle, `rvalid`, `err_corr`, `err_uncorr` and `wr_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, taken when `ready` is high |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| be | input | 8 | Byte enables for writes; bit b covers data bits 8b+7:8b |
| wdata | input | 64 | Write data |
| ready | output | 1 | Request can be taken this cycle |
| rvalid | output | 1 | Read response cycle |
| rdata | output | 64 | Corrected read data |
| err_corr | output | 1 | Single-bit fault corrected in this response or merge |
| err_uncorr | output | 1 | Uncorrectable fault seen in this response or merge |
| wr_err | output | 1 | Read-modify-write aborted by an uncorrectable old word |
| inj_set | input | 1 | Arm a fault injection |
| inj_idx | input | 7 | Codeword bit to invert (0..71) |
| inj_double | input | 1 | Also invert bit `inj_idx`+1 |
| init_done | output | 1 | Zero-fill sweep finished |

## Verification
The bench steers a behavioural model that records, for each word, the data written to it and how many of its bits were inverted. Against that model it drives the cases a careless design would get wrong. The first is a read-modify-write over a double fault. A design that commits the merge anyway would return a clean but wrong word instead of keeping the error. The second is a read-modify-write over a single fault, where a design that merges the raw, uncorrected bytes would store a bad word. The bench also arms an injection before an aborted merge. A design that consumes the injection on the abort would let the following write read back clean. Faults placed in check bits and the back-to-back reads catch codecs that correct only data bits, and read paths that lose one response.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;

  localparam int DW = 64;
  localparam int CB = 8;
  localparam int CW = DW + CB;

  typedef struct packed {
    logic [DW-1:0] data;
    logic          corr;
    logic          uncorr;
  } dec_t;

  // XOR of the Hamming positions of all set data bits; data bits fill the
  // non-power-of-two positions 3..71 in ascending order.
  function automatic logic [6:0] pos_xor(input logic [DW-1:0] d);
    logic [6:0] acc;
    logic [6:0] k;
    acc = '0;
    k   = '0;
    for (int p = 1; p < CW; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[k[5:0]]) acc = acc ^ 7'(p);
        k = k + 7'd1;
      end
    end
    return acc;
  endfunction

  function automatic logic [CW-1:0] ecc_encode(input logic [DW-1:0] d);
    logic [6:0] hp;
    hp = pos_xor(d);
    return {(^d) ^ (^hp), hp, d};
  endfunction

  function automatic dec_t ecc_decode(input logic [CW-1:0] cw);
    dec_t       r;
    logic [6:0] syn;
    logic       ov;
    logic [6:0] k;
    r.data   = cw[DW-1:0];
    r.corr   = 1'b0;
    r.uncorr = 1'b0;
    syn = pos_xor(cw[DW-1:0]) ^ cw[DW+6:DW];
    ov  = ^cw;
    if (!ov && syn != 7'd0) begin
      r.uncorr = 1'b1;
    end else if (ov) begin
      if (syn == 7'd0 || (syn & (syn - 7'd1)) == 7'd0) begin
        r.corr = 1'b1;
      end else if (syn > 7'd71) begin
        r.uncorr = 1'b1;
      end else begin
        r.corr = 1'b1;
        k = '0;
        for (int p = 1; p < CW; p++) begin
          if ((p & (p - 1)) != 0) begin
            if (7'(p) == syn) r.data[k[5:0]] = ~r.data[k[5:0]];
            k = k + 7'd1;
          end
        end
      end
    end
    return r;
  endfunction

  function automatic logic [CW-1:0] inj_mask(input logic [6:0] idx, input logic dbl);
    logic [CW-1:0] m;
    m = '0;
    if ({1'b0, idx} < 8'(CW)) m[idx] = 1'b1;
    if (dbl && ({1'b0, idx} + 8'd1) < 8'(CW)) m[idx + 7'd1] = 1'b1;
    return m;
  endfunction

  function automatic logic [DW-1:0] byte_merge(input logic [DW-1:0] oldw,
                                               input logic [DW-1:0] neww,
                                               input logic [7:0]    en);
    logic [DW-1:0] r;
    for (int b = 0; b < 8; b++)
      r[8*b +: 8] = en[b] ? neww[8*b +: 8] : oldw[8*b +: 8];
    return r;
  endfunction

endpackage

// File: rtl/ecc_sram_array.sv
module ecc_sram_array #(
  parameter int AW = 4,
  parameter int W  = 72
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_word,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_word
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_word;
    if (rd_en) rd_word <= mem[rd_addr];
  end
endmodule

// File: rtl/ecc_sram_init.sv
module ecc_sram_init #(
  parameter int AW      = 4,
  parameter bit INIT_ON = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          busy,
  output logic [AW-1:0] fill_addr,
  output logic          done
);
  localparam int DEPTH = 1 << AW;

  generate
    if (INIT_ON) begin : g_sweep
      logic [AW-1:0] cnt;
      logic          done_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt    <= '0;
          done_q <= 1'b0;
        end else if (!done_q) begin
          cnt <= cnt + 1'b1;
          if (cnt == AW'(DEPTH - 1)) done_q <= 1'b1;
        end
      end
      assign busy      = !done_q;
      assign fill_addr = cnt;
      assign done      = done_q;
    end else begin : g_skip
      logic done_q;
      always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= 1'b1;
      end
      assign busy      = 1'b0;
      assign fill_addr = '0;
      assign done      = done_q;
    end
  endgenerate
endmodule

// File: rtl/ecc_sram_wrap.sv
module ecc_sram_wrap
  import ecc_sram_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter bit INIT_ON = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        be,
  input  logic [63:0]       wdata,
  output logic              ready,
  output logic              rvalid,
  output logic [63:0]       rdata,
  output logic              err_corr,
  output logic              err_uncorr,
  output logic              wr_err,
  input  logic              inj_set,
  input  logic [6:0]        inj_idx,
  input  logic              inj_double,
  output logic              init_done
);
  typedef enum logic [1:0] {PH_IDLE, PH_RESP, PH_RMW} phase_t;

  phase_t            phase_q;
  logic              accept, full_wr, host_wr, commit_rmw, arr_we;
  logic [ADDR_W-1:0] arr_waddr, hold_addr, fill_addr;
  logic [CW-1:0]     arr_wword, arr_rword, flip;
  logic [7:0]        hold_be;
  logic [DW-1:0]     hold_data, merged;
  logic              fill_busy;
  logic              inj_armed;
  logic [6:0]        inj_idx_q;
  logic              inj_dbl_q;
  dec_t              dec;

  ecc_sram_init #(.AW(ADDR_W), .INIT_ON(INIT_ON)) u_init (
    .clk(clk), .rst_n(rst_n), .busy(fill_busy), .fill_addr(fill_addr), .done(init_done)
  );

  assign ready      = init_done && (phase_q != PH_RMW);
  assign accept     = req && ready;
  assign full_wr    = accept && we && (be == 8'hFF);
  assign dec        = ecc_decode(arr_rword);
  assign merged     = byte_merge(dec.data, hold_data, hold_be);
  assign commit_rmw = (phase_q == PH_RMW) && !dec.uncorr;
  assign host_wr    = full_wr || commit_rmw;
  assign flip       = inj_armed ? inj_mask(inj_idx_q, inj_dbl_q) : '0;

  always_comb begin
    arr_we    = 1'b0;
    arr_waddr = '0;
    arr_wword = '0;
    if (fill_busy) begin
      arr_we    = 1'b1;
      arr_waddr = fill_addr;
      arr_wword = ecc_encode('0);
    end else if (full_wr) begin
      arr_we    = 1'b1;
      arr_waddr = addr;
      arr_wword = ecc_encode(wdata) ^ flip;
    end else if (commit_rmw) begin
      arr_we    = 1'b1;
      arr_waddr = hold_addr;
      arr_wword = ecc_encode(merged) ^ flip;
    end
  end

  ecc_sram_array #(.AW(ADDR_W), .W(CW)) u_array (
    .clk(clk), .wr_en(arr_we), .wr_addr(arr_waddr), .wr_word(arr_wword),
    .rd_en(accept && !full_wr), .rd_addr(addr), .rd_word(arr_rword)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      hold_addr <= '0;
      hold_be   <= '0;
      hold_data <= '0;
    end else begin
      if (accept && !we)          phase_q <= PH_RESP;
      else if (accept && !full_wr) phase_q <= PH_RMW;
      else                         phase_q <= PH_IDLE;
      if (accept && we) begin
        hold_addr <= addr;
        hold_be   <= be;
        hold_data <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inj_armed <= 1'b0;
      inj_idx_q <= '0;
      inj_dbl_q <= 1'b0;
    end else if (inj_set) begin
      inj_armed <= 1'b1;
      inj_idx_q <= inj_idx;
      inj_dbl_q <= inj_double;
    end else if (host_wr) begin
      inj_armed <= 1'b0;
    end
  end

  assign rvalid     = (phase_q == PH_RESP);
  assign rdata      = rvalid ? dec.data : '0;
  assign err_corr   = (phase_q != PH_IDLE) && dec.corr;
  assign err_uncorr = (phase_q != PH_IDLE) && dec.uncorr;
  assign wr_err     = (phase_q == PH_RMW) && dec.uncorr;
endmodule

// File: rtl/ecc_sram_chk.sv
module ecc_sram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req,
  input logic       we,
  input logic [7:0] be,
  input logic       ready,
  input logic       rvalid,
  input logic       err_corr,
  input logic       err_uncorr,
  input logic       wr_err,
  input logic       init_done,
  input logic       inj_set,
  input logic       host_wr,
  input logic       inj_armed
);
  assert_busy_until_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !ready);
  assert_init_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  assert_full_write_no_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ready && we && be == 8'hFF) |=> ready);
  assert_read_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ready && !we) |=> rvalid);
  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_corr && err_uncorr));
  assert_rmw_one_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ready && we && be != 8'hFF) |=> (!ready ##1 ready));
  assert_abort_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> (err_uncorr && !rvalid && !ready));
  assert_inj_oneshot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && inj_armed && !inj_set) |=> !inj_armed);
  assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !rvalid) |-> (!err_corr && !err_uncorr && !wr_err));
endmodule

bind ecc_sram_wrap ecc_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .be(be), .ready(ready),
  .rvalid(rvalid), .err_corr(err_corr), .err_uncorr(err_uncorr), .wr_err(wr_err),
  .init_done(init_done), .inj_set(inj_set), .host_wr(host_wr), .inj_armed(inj_armed)
);

// File: tb/ecc_sram_wrap_tb.sv
module ecc_sram_wrap_tb;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    be = '0;
  logic [63:0]   wdata = '0;
  logic          ready, rvalid, err_corr, err_uncorr, wr_err, init_done;
  logic [63:0]   rdata;
  logic          inj_set = 1'b0, inj_double = 1'b0;
  logic [6:0]    inj_idx = '0;

  always #5 clk = ~clk;

  ecc_sram_wrap #(.ADDR_W(AW), .INIT_ON(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .be(be), .wdata(wdata),
    .ready(ready), .rvalid(rvalid), .rdata(rdata), .err_corr(err_corr),
    .err_uncorr(err_uncorr), .wr_err(wr_err), .inj_set(inj_set), .inj_idx(inj_idx),
    .inj_double(inj_double), .init_done(init_done)
  );

  // reference model: data and number of inverted bits per word
  logic [63:0] mdata [DEPTH];
  int          mflips [DEPTH];
  int          inj_cnt = 0;
  logic        exp_ready = 1'b0;
  int          n_cmp = 0, n_bad = 0;
  bit          finished = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check(ready == exp_ready, "ready R6", 64'(ready), 64'(exp_ready));
  endtask

  task automatic rd(input int a, input string tag);
    req = 1'b1; we = 1'b0; addr = AW'(a); be = '0;
    exp_ready = 1'b1;
    tick();
    check(rvalid == 1'b1, {tag, " rvalid R3"}, 64'(rvalid), 64'd1);
    if (mflips[a] < 2) begin
      check(rdata == mdata[a], {tag, " rdata"}, rdata, mdata[a]);
      check(err_corr == (mflips[a] == 1), {tag, " err_corr"}, 64'(err_corr), 64'(mflips[a] == 1));
      check(err_uncorr == 1'b0, {tag, " err_uncorr"}, 64'(err_uncorr), 64'd0);
    end else begin
      check(err_uncorr == 1'b1, {tag, " err_uncorr R5"}, 64'(err_uncorr), 64'd1);
      check(err_corr == 1'b0, {tag, " err_corr R5"}, 64'(err_corr), 64'd0);
    end
    req = 1'b0;
  endtask

  task automatic wr(input int a, input logic [7:0] b, input logic [63:0] d, input string tag);
    req = 1'b1; we = 1'b1; addr = AW'(a); be = b; wdata = d;
    if (b == 8'hFF) begin
      exp_ready = 1'b1;
      tick();
      req = 1'b0;
      mdata[a] = d; mflips[a] = inj_cnt; inj_cnt = 0;
    end else begin
      exp_ready = 1'b0;
      tick();
      req = 1'b0;
      check(rvalid == 1'b0, {tag, " rvalid in merge"}, 64'(rvalid), 64'd0);
      if (mflips[a] == 2) begin
        check(wr_err == 1'b1, {tag, " wr_err R7"}, 64'(wr_err), 64'd1);
        check(err_uncorr == 1'b1, {tag, " err_uncorr R7"}, 64'(err_uncorr), 64'd1);
      end else begin
        check(wr_err == 1'b0, {tag, " wr_err"}, 64'(wr_err), 64'd0);
        check(err_corr == (mflips[a] == 1), {tag, " err_corr R8"}, 64'(err_corr), 64'(mflips[a] == 1));
        for (int k = 0; k < 8; k++)
          if (b[k]) mdata[a][8*k +: 8] = d[8*k +: 8];
        mflips[a] = inj_cnt; inj_cnt = 0;
      end
      exp_ready = 1'b1;
      tick();
    end
  endtask

  task automatic arm(input int idx, input bit dbl);
    inj_set = 1'b1; inj_idx = 7'(idx); inj_double = dbl;
    exp_ready = 1'b1;
    tick();
    inj_set = 1'b0;
    inj_cnt = dbl ? 2 : 1;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mdata[i] = '0; mflips[i] = 0; end
    repeat (3) @(negedge clk);
    check(ready == 1'b0 && init_done == 1'b0, "reset state R1", {62'd0, ready, init_done}, 64'd0);
    rst_n = 1'b1;
    begin
      int cyc;
      cyc = 0;
      while (!init_done && cyc < 100) begin
        @(posedge clk); @(negedge clk);
        cyc++;
        if (!init_done) check(ready == 1'b0, "ready during init R1", 64'(ready), 64'd0);
      end
      check(cyc == DEPTH, "init length R1", 64'(cyc), 64'(DEPTH));
    end
    rd(0, "R1 zero");
    rd(5, "R1 zero");
    rd(15, "R1 zero");
    wr(3, 8'hFF, 64'hDEAD_BEEF_0123_4567, "R2");
    check(ready == 1'b1, "R2 no stall", 64'(ready), 64'd1);
    rd(3, "R2 readback");
    wr(4, 8'hFF, 64'hA5A5_5A5A_FFFF_0000, "R2");
    rd(3, "R3 back-to-back");
    rd(4, "R3 back-to-back");
    wr(3, 8'h0F, 64'h1111_2222_3333_4444, "R6");
    rd(3, "R6 merge");
    wr(4, 8'hA0, 64'h9988_7766_5544_3322, "R6");
    rd(4, "R6 merge");
    arm(5, 1'b0);
    wr(7, 8'hFF, 64'h0F0F_0F0F_F0F0_F0F0, "R9");
    rd(7, "R4 data-bit fault");
    wr(8, 8'hFF, 64'h1234_5678_9ABC_DEF0, "R9");
    rd(8, "R9 disarmed");
    arm(66, 1'b0);
    wr(9, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, "R9");
    rd(9, "R4 check-bit fault");
    arm(71, 1'b0);
    wr(13, 8'hFF, 64'h0000_0000_0000_0001, "R9");
    rd(13, "R4 overall-bit fault");
    arm(10, 1'b1);
    wr(10, 8'hFF, 64'h5555_AAAA_5555_AAAA, "R9");
    rd(10, "R5 double fault");
    wr(10, 8'h01, 64'h0000_0000_0000_00FF, "R7");
    rd(10, "R7 kept fault");
    arm(20, 1'b0);
    wr(10, 8'h02, 64'h0000_0000_0000_FF00, "R7 abort keeps arm");
    wr(11, 8'hFF, 64'hCAFE_F00D_CAFE_F00D, "R9");
    rd(11, "R9 arm survives abort");
    wr(7, 8'hC0, 64'hABCD_0000_0000_0000, "R8");
    rd(7, "R8 merged clean");
    arm(40, 1'b0);
    wr(12, 8'hFF, 64'h0BAD_C0DE_1357_2468, "R9");
    rd(12, "R10 before scrub");
    wr(12, 8'hFF, mdata[12], "R10");
    rd(12, "R10 after scrub");
    exp_ready = 1'b1;
    tick();
    check(!rvalid && !err_corr && !err_uncorr && !wr_err, "R11 idle quiet",
          {60'd0, rvalid, err_corr, err_uncorr, wr_err}, 64'd0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule